// File: doc/BRIEF.md
# Cut-Aware Primitive Index Assembler

This block turns a stream of vertex indices into primitives. It takes one index per cycle. Each index comes with a restart flag, a stream-end flag and a valid/ready handshake. A selected topology decides how the indices are grouped, and each finished primitive's vertex indices are written into the next free slot of a batch. Point, line and triangle lists are supported, as are line and triangle strips. There are also three adjacency variants, which can emit either their full vertex set or a reduced line or triangle for pipelines that have no geometry stage.

A batch is handed to the consumer in two cases: when every slot is filled, or when the vertex marked as the end of the stream has been taken in. While a batch waits, the input is stalled. A primitive that is only partly collected stays in the assembly window across the batch boundary. The restart flag drops any partial primitive and resets the strip winding, so independent strips can be packed into one stream.

Top module: `prim_idx_asm`

## Requirements
- R1: Out of reset, `batch_valid` is 0, `batch_count` is 0 and `in_ready` is 1.
- R2: With `topo`=0 (points), each accepted vertex becomes a one-vertex primitive. With `topo`=1 (line list), every two vertices form a line (first, second) and the count then starts again from zero.
- R3: With `topo`=2 (line strip), the first line is made from the first two vertices. After that, each new vertex forms a line with the vertex before it.
- R4: With `topo`=3 (triangle list), every three vertices form a triangle in arrival order. Collection then starts again from zero.
- R5: With `topo`=4 (triangle strip), a triangle is emitted when three vertices are held, and the last two are kept for the next one. The winding flag toggles after each triangle. While it is set, output positions 1 and 2 are swapped. Position 0 is always the oldest held vertex.
- R6: An accepted vertex with `in_cut`=1 clears the partial primitive and the winding flag. When `keep_cut`=0, that vertex contributes to no primitive.
- R7: When `keep_cut`=1, a cut vertex is first fed to the topology logic as an ordinary vertex, and may complete a primitive. The restart of R6 is applied after that.
- R8: With `topo`=5 (line list with adjacency), four vertices are collected and the count then clears. `full_adj`=1 emits all four in order. `full_adj`=0 emits only the 2nd and 3rd as a line.
- R9: With `topo`=6 (line strip with adjacency), a four-vertex window emits once full and then keeps its last three vertices. `full_adj`=1 emits all four. `full_adj`=0 emits window positions 1 and 2.
- R10: With `topo`=7 (triangle list with adjacency), six vertices are collected and the count then clears. `full_adj`=1 emits all six in order. `full_adj`=0 emits the 1st, 3rd and 5th as a triangle.
- R11: When a primitive fills the last of `SLOTS` slots, `batch_valid` rises and `in_ready` falls. Both hold until `batch_ready` is seen. A partial primitive, and the strip winding, carry over into the next batch.
- R12: Accepting a vertex with `in_last`=1 presents the batch with `batch_count` equal to the number of primitives in it. The count is 0 if there are none.
- R13: Slot s, vertex position v sits at `batch_idx[(s*6+v)*IDX_W +: IDX_W]`. Positions a primitive does not use read 0, and so do slots at or above `batch_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| topo | input | 3 | Topology code (0..7, see R2 to R10) |
| full_adj | input | 1 | Adjacency topologies emit the full vertex set when 1, reduced when 0 |
| keep_cut | input | 1 | Feed cut-flagged vertices to the topology before restarting |
| in_valid | input | 1 | Input vertex valid |
| in_ready | output | 1 | Block can accept a vertex |
| in_idx | input | IDX_W | Vertex index |
| in_cut | input | 1 | Restart flag for this vertex |
| in_last | input | 1 | Final vertex of the stream |
| batch_valid | output | 1 | Batch presented |
| batch_ready | input | 1 | Consumer takes the batch |
| batch_count | output | $clog2(SLOTS+1) | Number of valid primitive slots |
| batch_idx | output | SLOTS*6*IDX_W | Slot-major primitive vertex indices |

## Verification
The bench builds the block with `SLOTS`=4 and `IDX_W`=12. With the smaller batch, a triangle strip of six vertices fills a batch, so the stall and the carry-over of window and winding into the following batch are both reached by short sequences. The partial flushes leave slots above the count unused, which brings the zero-fill of R13 into view. The 12-bit index width keeps vertex numbers distinct from the zero fill.

// File: rtl/prim_asm_pkg.sv
// Shared definitions for the primitive index assembler.
// Assumes at most six vertices per emitted primitive.
package prim_asm_pkg;
    localparam int PRIM_VERTS = 6;
    localparam int WIN_DEPTH  = PRIM_VERTS - 1;

    typedef enum logic [2:0] {
        TOPO_POINTS     = 3'd0,
        TOPO_LINES      = 3'd1,
        TOPO_LSTRIP     = 3'd2,
        TOPO_TRIS       = 3'd3,
        TOPO_TSTRIP     = 3'd4,
        TOPO_LINES_ADJ  = 3'd5,
        TOPO_LSTRIP_ADJ = 3'd6,
        TOPO_TRIS_ADJ   = 3'd7
    } topo_e;
endpackage

// File: rtl/prim_window.sv
// Assembly window: holds partly collected vertices for the selected topology,
// and on each step decides whether a primitive completes and which vertices it carries.
// Assumes topo, full_adj and keep_cut stay constant within a primitive.
module prim_window
    import prim_asm_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    input  logic [2:0]                  topo,
    input  logic                        full_adj,
    input  logic                        keep_cut,
    input  logic [IDX_W-1:0]            vin,
    input  logic                        cut,
    output logic                        emit,
    output logic [PRIM_VERTS*IDX_W-1:0] prim
);
    logic [IDX_W-1:0] win_q [WIN_DEPTH];
    logic [IDX_W-1:0] win_d [WIN_DEPTH];
    logic [IDX_W-1:0] pv    [PRIM_VERTS];
    logic [2:0]       cnt_q, cnt_d;
    logic             wind_q, wind_d;
    logic             done;
    logic             feed;

    assign feed = !cut || keep_cut;
    assign emit = step && feed && done;

    // Pack the per-position vertex values into the primitive bus.
    for (genvar v = 0; v < PRIM_VERTS; v++) begin : g_pack
        assign prim[v*IDX_W +: IDX_W] = pv[v];
    end

    // Next-state and primitive selection for one incoming vertex.
    always_comb begin
        win_d  = win_q;
        cnt_d  = cnt_q;
        wind_d = wind_q;
        done   = 1'b0;
        for (int v = 0; v < PRIM_VERTS; v++) pv[v] = '0;
        if (feed) begin
            unique case (topo_e'(topo))
                TOPO_POINTS: begin
                    done  = 1'b1;
                    pv[0] = vin;
                end
                TOPO_LINES, TOPO_LSTRIP: begin
                    if (cnt_q == 3'd1) begin
                        done  = 1'b1;
                        pv[0] = win_q[0];
                        pv[1] = vin;
                        if (topo_e'(topo) == TOPO_LSTRIP) win_d[0] = vin;
                        else cnt_d = 3'd0;
                    end else begin
                        win_d[0] = vin;
                        cnt_d    = 3'd1;
                    end
                end
                TOPO_TRIS, TOPO_TSTRIP: begin
                    if (cnt_q == 3'd2) begin
                        done  = 1'b1;
                        pv[0] = win_q[0];
                        if (topo_e'(topo) == TOPO_TSTRIP) begin
                            pv[1]    = wind_q ? vin : win_q[1];
                            pv[2]    = wind_q ? win_q[1] : vin;
                            win_d[0] = win_q[1];
                            win_d[1] = vin;
                            wind_d   = !wind_q;
                        end else begin
                            pv[1] = win_q[1];
                            pv[2] = vin;
                            cnt_d = 3'd0;
                        end
                    end else begin
                        for (int i = 0; i < 2; i++) if (cnt_q == 3'(i)) win_d[i] = vin;
                        cnt_d = cnt_q + 3'd1;
                    end
                end
                TOPO_LINES_ADJ, TOPO_LSTRIP_ADJ: begin
                    if (cnt_q == 3'd3) begin
                        done = 1'b1;
                        if (full_adj) begin
                            pv[0] = win_q[0];
                            pv[1] = win_q[1];
                            pv[2] = win_q[2];
                            pv[3] = vin;
                        end else begin
                            pv[0] = win_q[1];
                            pv[1] = win_q[2];
                        end
                        if (topo_e'(topo) == TOPO_LSTRIP_ADJ) begin
                            win_d[0] = win_q[1];
                            win_d[1] = win_q[2];
                            win_d[2] = vin;
                        end else begin
                            cnt_d = 3'd0;
                        end
                    end else begin
                        for (int i = 0; i < 3; i++) if (cnt_q == 3'(i)) win_d[i] = vin;
                        cnt_d = cnt_q + 3'd1;
                    end
                end
                default: begin
                    if (cnt_q == 3'd5) begin
                        done = 1'b1;
                        if (full_adj) begin
                            for (int i = 0; i < WIN_DEPTH; i++) pv[i] = win_q[i];
                            pv[5] = vin;
                        end else begin
                            pv[0] = win_q[0];
                            pv[1] = win_q[2];
                            pv[2] = win_q[4];
                        end
                        cnt_d = 3'd0;
                    end else begin
                        for (int i = 0; i < WIN_DEPTH; i++) if (cnt_q == 3'(i)) win_d[i] = vin;
                        cnt_d = cnt_q + 3'd1;
                    end
                end
            endcase
        end
        if (cut) begin
            cnt_d  = 3'd0;
            wind_d = 1'b0;
        end
    end

    // Window, count and winding registers advance only on an accepted vertex.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= 3'd0;
            wind_q <= 1'b0;
            for (int i = 0; i < WIN_DEPTH; i++) win_q[i] <= '0;
        end else if (step) begin
            cnt_q  <= cnt_d;
            wind_q <= wind_d;
            for (int i = 0; i < WIN_DEPTH; i++) win_q[i] <= win_d[i];
        end
    end

    // A cut leaves an empty window with the winding cleared.
    p_cut_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step && cut |=> cnt_q == 3'd0 && !wind_q);
    // The window never holds more than the largest partial primitive.
    p_window_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 3'd5);
    // Only the triangle strip ever sets the winding flag.
    p_wind_strip_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step && topo_e'(topo) != TOPO_TSTRIP |=> !wind_q);
endmodule

// File: rtl/prim_batch.sv
// Batch store: writes emitted primitives into consecutive slots, presents the batch
// when full or at stream end, and clears when the consumer takes it.
// Assumes no primitive is emitted while the batch is presented.
module prim_batch
    import prim_asm_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int SLOTS = 8,
    localparam int CW     = $clog2(SLOTS + 1),
    localparam int SLOT_W = PRIM_VERTS * IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    emit,
    input  logic [SLOT_W-1:0]       prim,
    input  logic                    last_fire,
    input  logic                    batch_ready,
    output logic                    batch_valid,
    output logic [CW-1:0]           batch_count,
    output logic [SLOTS*SLOT_W-1:0] batch_idx
);
    logic [SLOT_W-1:0] slot_q [SLOTS];
    logic              take;

    assign take = batch_valid && batch_ready;

    // One register per slot, written when it is the next free one.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || take) slot_q[s] <= '0;
            else if (emit && batch_count == CW'(s)) slot_q[s] <= prim;
        end
        assign batch_idx[s*SLOT_W +: SLOT_W] = slot_q[s];
    end

    // Slot count and presentation flag.
    always_ff @(posedge clk) begin
        if (!rst_n || take) begin
            batch_count <= '0;
            batch_valid <= 1'b0;
        end else begin
            if (emit) batch_count <= batch_count + CW'(1);
            if ((emit && batch_count == CW'(SLOTS - 1)) || last_fire) batch_valid <= 1'b1;
        end
    end

    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        batch_count <= CW'(SLOTS));
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        batch_valid && !batch_ready |=> batch_valid && $stable(batch_count) && $stable(batch_idx));
    p_no_emit_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        batch_valid |-> !emit);
    p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        last_fire |=> batch_valid);
endmodule

// File: rtl/prim_idx_asm.sv
// Top of the primitive index assembler: accepts vertices under valid/ready,
// steps the assembly window and fills the batch store.
// Assumes the consumer eventually raises batch_ready.
module prim_idx_asm
    import prim_asm_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int SLOTS = 8,
    localparam int CW     = $clog2(SLOTS + 1),
    localparam int SLOT_W = PRIM_VERTS * IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              topo,
    input  logic                    full_adj,
    input  logic                    keep_cut,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [IDX_W-1:0]        in_idx,
    input  logic                    in_cut,
    input  logic                    in_last,
    output logic                    batch_valid,
    input  logic                    batch_ready,
    output logic [CW-1:0]           batch_count,
    output logic [SLOTS*SLOT_W-1:0] batch_idx
);
    logic              step;
    logic              emit;
    logic [SLOT_W-1:0] prim;

    assign in_ready = !batch_valid;
    assign step     = in_valid && in_ready;

    prim_window #(.IDX_W(IDX_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .topo     (topo),
        .full_adj (full_adj),
        .keep_cut (keep_cut),
        .vin      (in_idx),
        .cut      (in_cut),
        .emit     (emit),
        .prim     (prim)
    );

    prim_batch #(.IDX_W(IDX_W), .SLOTS(SLOTS)) u_batch (
        .clk         (clk),
        .rst_n       (rst_n),
        .emit        (emit),
        .prim        (prim),
        .last_fire   (step && in_last),
        .batch_ready (batch_ready),
        .batch_valid (batch_valid),
        .batch_count (batch_count),
        .batch_idx   (batch_idx)
    );

    // A taken batch leaves an empty store on the following cycle.
    p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        batch_valid && batch_ready |=> !batch_valid && batch_count == '0);
    // Every point-list vertex produces exactly one slot.
    p_point_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step && !in_cut && topo == 3'd0 |=> batch_count == $past(batch_count) + CW'(1));
endmodule

// File: tb/sim_prim_idx_asm.sv
module sim_prim_idx_asm;
    localparam int IW = 12;
    localparam int NS = 4;
    localparam int CW = $clog2(NS + 1);

    logic clk = 0, rst_n = 0;
    logic [2:0] topo = 0;
    logic full_adj = 0, keep_cut = 0;
    logic in_valid = 0, in_cut = 0, in_last = 0, batch_ready = 0;
    logic [IW-1:0] in_idx = 0;
    logic in_ready, batch_valid;
    logic [CW-1:0] batch_count;
    logic [NS*6*IW-1:0] batch_idx;

    int checks = 0, fails = 0;
    int exp_n = 0;
    int exp_v [NS][6];

    always #10 clk = ~clk;

    prim_idx_asm #(.IDX_W(IW), .SLOTS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .topo(topo), .full_adj(full_adj), .keep_cut(keep_cut),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_cut(in_cut),
        .in_last(in_last), .batch_valid(batch_valid), .batch_ready(batch_ready),
        .batch_count(batch_count), .batch_idx(batch_idx));

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send(input int v, input bit c, input bit l);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_idx = IW'(v); in_cut = c; in_last = l;
        @(negedge clk);
        in_valid = 0; in_cut = 0; in_last = 0;
    endtask

    task automatic add_prim(input int a, input int b, input int c,
                            input int d, input int e, input int f);
        exp_v[exp_n][0] = a; exp_v[exp_n][1] = b; exp_v[exp_n][2] = c;
        exp_v[exp_n][3] = d; exp_v[exp_n][4] = e; exp_v[exp_n][5] = f;
        exp_n++;
    endtask

    // Wait for a batch, compare count and every slot (R13 zero fill), then take it.
    task automatic check_batch(input string req);
        int t = 0;
        while (!batch_valid && t < 100) begin @(negedge clk); t++; end
        chk({req, " valid"}, int'(batch_valid), 1);
        chk({req, " count"}, int'(batch_count), exp_n);
        for (int s = 0; s < NS; s++) begin
            int bad = -1, g = 0, e = 0;
            for (int v = 0; v < 6; v++) begin
                int gv = int'(batch_idx[(s*6+v)*IW +: IW]);
                int ev = (s < exp_n) ? exp_v[s][v] : 0;
                if (gv != ev && bad < 0) begin bad = v; g = gv; e = ev; end
            end
            chk($sformatf("%s/R13 slot %0d pos %0d", req, s, bad < 0 ? 0 : bad), g, e);
        end
        @(negedge clk); batch_ready = 1;
        @(negedge clk); batch_ready = 0;
        exp_n = 0;
        for (int s = 0; s < NS; s++) for (int v = 0; v < 6; v++) exp_v[s][v] = 0;
    endtask

    task automatic restart();
        keep_cut = 0;
        send(0, 1, 0);
    endtask

    task automatic t_reset();
        chk("R1 batch_valid", int'(batch_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 count", int'(batch_count), 0);
    endtask

    task automatic t_points();
        topo = 0; restart();
        send(10, 0, 0); send(11, 0, 0); send(12, 0, 1);
        add_prim(10,0,0,0,0,0); add_prim(11,0,0,0,0,0); add_prim(12,0,0,0,0,0);
        check_batch("R2 points R12");
    endtask

    task automatic t_lines();
        topo = 1; restart();
        for (int i = 1; i <= 5; i++) send(i, 0, i == 5);
        add_prim(1,2,0,0,0,0); add_prim(3,4,0,0,0,0);
        check_batch("R2 line list");
    endtask

    task automatic t_lstrip();
        topo = 2; restart();
        for (int i = 1; i <= 4; i++) send(i, 0, i == 4);
        add_prim(1,2,0,0,0,0); add_prim(2,3,0,0,0,0); add_prim(3,4,0,0,0,0);
        check_batch("R3 line strip");
    endtask

    task automatic t_tris();
        topo = 3; restart();
        for (int i = 1; i <= 7; i++) send(i, 0, i == 7);
        add_prim(1,2,3,0,0,0); add_prim(4,5,6,0,0,0);
        check_batch("R4 tri list");
    endtask

    task automatic t_tstrip_full();
        topo = 4; restart();
        for (int i = 1; i <= 6; i++) send(i, 0, 0);
        chk("R11 in_ready low when full", int'(in_ready), 0);
        add_prim(1,2,3,0,0,0); add_prim(2,4,3,0,0,0);
        add_prim(3,4,5,0,0,0); add_prim(4,6,5,0,0,0);
        check_batch("R5 tri strip R11 full");
        chk("R11 in_ready after take", int'(in_ready), 1);
        send(7, 0, 1);
        add_prim(5,6,7,0,0,0);
        check_batch("R11 carry-over R5");
    endtask

    task automatic t_cut();
        topo = 4; restart();
        for (int i = 1; i <= 4; i++) send(i, 0, 0);
        send(9, 1, 0);
        send(5, 0, 0); send(6, 0, 0); send(7, 0, 1);
        add_prim(1,2,3,0,0,0); add_prim(2,4,3,0,0,0); add_prim(5,6,7,0,0,0);
        check_batch("R6 cut restart");
    endtask

    task automatic t_keep_cut();
        topo = 2; restart();
        keep_cut = 1;
        send(1, 0, 0); send(2, 0, 0); send(3, 1, 0); send(4, 0, 0); send(5, 0, 1);
        add_prim(1,2,0,0,0,0); add_prim(2,3,0,0,0,0); add_prim(4,5,0,0,0,0);
        check_batch("R7 keep cut");
        keep_cut = 0;
    endtask

    task automatic t_lines_adj();
        topo = 5; restart();
        full_adj = 1;
        for (int i = 1; i <= 4; i++) send(i, 0, 0);
        full_adj = 0;
        for (int i = 5; i <= 8; i++) send(i, 0, i == 8);
        add_prim(1,2,3,4,0,0); add_prim(6,7,0,0,0,0);
        check_batch("R8 line list adj");
    endtask

    task automatic t_lstrip_adj();
        topo = 6; restart();
        full_adj = 0;
        for (int i = 1; i <= 6; i++) send(i, 0, i == 6);
        add_prim(2,3,0,0,0,0); add_prim(3,4,0,0,0,0); add_prim(4,5,0,0,0,0);
        check_batch("R9 line strip adj reduced");
        restart();
        full_adj = 1;
        for (int i = 1; i <= 5; i++) send(i, 0, i == 5);
        add_prim(1,2,3,4,0,0); add_prim(2,3,4,5,0,0);
        check_batch("R9 line strip adj full");
    endtask

    task automatic t_tris_adj();
        topo = 7; restart();
        full_adj = 1;
        for (int i = 1; i <= 6; i++) send(i, 0, 0);
        full_adj = 0;
        for (int i = 7; i <= 12; i++) send(i, 0, i == 12);
        add_prim(1,2,3,4,5,6); add_prim(7,9,11,0,0,0);
        check_batch("R10 tri list adj");
    endtask

    task automatic t_empty_flush();
        topo = 3; restart();
        send(5, 1, 1);
        check_batch("R12 empty flush");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_points();
        t_lines();
        t_lstrip();
        t_tris();
        t_tstrip_full();
        t_cut();
        t_keep_cut();
        t_lines_adj();
        t_lstrip_adj();
        t_tris_adj();
        t_empty_flush();
        finish_run();
    end
endmodule